// File: doc/BRIEF.md
# CMI Receive Deserializer with Violation Flag

This block turns a serial receive stream into 8-bit parallel words. It runs on one clock, and every rising edge takes one serial sample. In the two NRZ modes each sample is one data bit. In the two CMI modes each data bit arrives as two half-bit samples. The block decodes those pairs, checks each symbol against the Coded Mark Inversion rules and flags any word that contains a badly coded bit. It packs bits first-received-most-significant, then presents each finished word together with its violation flag, a one-cycle word strobe and a derived byte clock. The parallel outputs change only as that byte clock falls.

A loopback select picks either the normal receive input or a diagnostic input as the serial source. The chosen stream is retimed by one register and driven out again as a loopback output. After reset the word boundary counts from the first sample. A realign input restarts the boundary at any sample the user chooses. The mode input and the loopback select are expected to change only between realigned sequences.

Top module: `cmi_rx_deser`

## Requirements
- R1: The mode input selects the decoding. 3'b000 (622.08 Mbit/s) and 3'b001 (155.52 Mbit/s) are NRZ, where each clock sample is one bit. 3'b010 (155.52 Mbit/s) and 3'b011 (139.264 Mbit/s) are CMI, where each bit takes two samples, the first half then the second half. The codes 3'b1xx behave as NRZ.
- R2: Within a word, the first bit received appears on pout[7] and the last bit received appears on pout[0].
- R3: In CMI, the half-bit pair (first, second) = (0,1) decodes to 0. The pairs (0,0) and (1,1) decode to 1.
- R4: In CMI, the pair (1,0) is a coding violation and decodes to 0.
- R5: In CMI, a 1 whose level equals the level of the previous 1 is a coding violation. The first 1 after reset, or after any time spent in an NRZ mode, is not checked.
- R6: lcv goes high with a word exactly when at least one of that word's eight bits was a violation. A violation never carries into the next word.
- R7: In the NRZ modes, lcv is low for every word.
- R8: pout and lcv change only on a falling edge of byte_clk. byte_clk is high for the second half of each word. byte_vld pulses for one cycle with each new word, and it never pulses on two cycles in a row.
- R9: While rst_n is low, pout, lcv, byte_vld, byte_clk and lb_out are cleared at the next edge. The first sample taken after reset is bit 7 of the first word, and no realignment happens until realign_en is raised.
- R10: A sample taken while realign_en is high starts a new word: in NRZ it is the first bit, and in CMI it is the first half of the first bit. Any partial word is discarded.
- R11: lb_en high selects diag_in as the serial source instead of rx_in. lb_out shows the selected sample one clock after it was taken.
- R12: For a word whose first sample is taken at edge n, pout, lcv and byte_vld update at edge n+8 in NRZ and at edge n+16 in CMI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one sample per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 3 | Line mode select (see R1) |
| rx_in | input | 1 | Normal serial receive input |
| diag_in | input | 1 | Diagnostic loopback serial input |
| lb_en | input | 1 | High selects diag_in as the source |
| realign_en | input | 1 | High marks the current sample as a word start |
| lb_out | output | 1 | Retimed copy of the selected serial stream |
| pout | output | 8 | Parallel word, bit 7 received first |
| lcv | output | 1 | Violation flag for the word on pout |
| byte_vld | output | 1 | One-cycle strobe with each new word |
| byte_clk | output | 1 | Byte clock; outputs change on its fall |

## Verification
Every cycle, the assertions check these properties:
- the reset clearing of the outputs;
- the one-cycle retiming of the chosen loopback source;
- that CMI produces at most one decoded bit every two samples;
- that pout and lcv move only on a falling byte_clk;
- that word strobes stay isolated;
- that lcv stays low on words completed in NRZ mode.

Only the directed scenarios can show the decoded values and the bit order. They also cover which symbol patterns raise lcv (a (1,0) pair, a repeated mark level), clearing of the flag on the next clean word, the exact latency in each mode, and the effect of realigning in the middle of a word.

// File: rtl/cmi_rx_pkg.sv
// Shared definitions for the CMI receive deserializer.
// Assumes a 3-bit mode code; only two codes select CMI decoding.
package cmi_rx_pkg;

    localparam logic [2:0] MODE_NRZ_FAST = 3'b000;
    localparam logic [2:0] MODE_NRZ_SLOW = 3'b001;
    localparam logic [2:0] MODE_CMI_FAST = 3'b010;
    localparam logic [2:0] MODE_CMI_SLOW = 3'b011;

    // True when the mode code selects two-sample CMI symbols.
    function automatic logic mode_is_cmi(input logic [2:0] m);
        return (m == MODE_CMI_FAST) || (m == MODE_CMI_SLOW);
    endfunction

endpackage

// File: rtl/cmi_rx_src_sel.sv
// Serial source selection and retiming stage.
// Picks the normal or the diagnostic input, registers the chosen sample
// (this register also drives the loopback output), and delays the realign
// request by the same one cycle so it stays aligned with its sample.
// Assumes lb_en changes only between realigned sequences.
module cmi_rx_src_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_in,
    input  logic diag_in,
    input  logic lb_en,
    input  logic realign_in,
    output logic sym_q,
    output logic realign_q,
    output logic live_q
);

    // Register the selected sample, its realign mark and a data-valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym_q     <= 1'b0;
            realign_q <= 1'b0;
            live_q    <= 1'b0;
        end else begin
            sym_q     <= lb_en ? diag_in : rx_in;
            realign_q <= realign_in;
            live_q    <= 1'b1;
        end
    end

    // R11: the diagnostic input reaches the retimed output one cycle later.
    assert_lb_diag_retime_R11: assert property (@(posedge clk) disable iff (!rst_n)
        lb_en |=> (sym_q == $past(diag_in)));

    // R11: the normal input reaches the retimed output one cycle later.
    assert_lb_norm_retime_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !lb_en |=> (sym_q == $past(rx_in)));

endmodule

// File: rtl/cmi_rx_sym_dec.sv
// Symbol decoder.
// In NRZ every valid sample is passed through as one bit with no error.
// In CMI two samples form one bit: equal halves give 1, the pair 0-then-1
// gives 0, and 1-then-0 is a violation that gives 0. The level of the last
// 1 is kept so that a 1 repeating it is also flagged. Mark history is
// dropped whenever the mode is not CMI.
// Assumes sym and restart are aligned samples from the source stage.
module cmi_rx_sym_dec (
    input  logic clk,
    input  logic rst_n,
    input  logic cmi_en,
    input  logic live,
    input  logic sym,
    input  logic restart,
    output logic bit_vld,
    output logic bit_val,
    output logic bit_err
);

    logic phase_q;      // 1: the first half-bit is held in half0_q
    logic half0_q;      // first half of the current CMI bit
    logic mark_lvl_q;   // level of the most recent decoded 1
    logic mark_known_q; // mark_lvl_q is meaningful

    logic pair_one;
    logic pair_bad;
    logic mark_rep;

    // Classify the current half-bit pair.
    always_comb begin
        pair_one = (half0_q == sym);
        pair_bad = half0_q & ~sym;
        mark_rep = pair_one & mark_known_q & (mark_lvl_q == sym);
    end

    // Produce one decoded bit per sample (NRZ) or per completed pair (CMI).
    always_comb begin
        bit_vld = 1'b0;
        bit_val = 1'b0;
        bit_err = 1'b0;
        if (!cmi_en) begin
            bit_vld = live;
            bit_val = sym;
        end else if (live && phase_q && !restart) begin
            bit_vld = 1'b1;
            bit_val = pair_one;
            bit_err = pair_bad | mark_rep;
        end
    end

    // Track pair phase and the alternating mark level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q      <= 1'b0;
            half0_q      <= 1'b0;
            mark_lvl_q   <= 1'b0;
            mark_known_q <= 1'b0;
        end else if (!cmi_en) begin
            phase_q      <= 1'b0;
            mark_known_q <= 1'b0;
        end else if (live) begin
            if (restart || !phase_q) begin
                half0_q <= sym;
                phase_q <= 1'b1;
            end else begin
                phase_q <= 1'b0;
                if (pair_one) begin
                    mark_lvl_q   <= sym;
                    mark_known_q <= 1'b1;
                end
            end
        end
    end

    // R1: in CMI a decoded bit is never followed directly by another.
    assert_cmi_half_rate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmi_en && bit_vld) |=> (!cmi_en || !bit_vld));

    // R7: no bit carries an error outside CMI.
    assert_nrz_no_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cmi_en |-> !bit_err);

endmodule

// File: rtl/cmi_rx_packer.sv
// Word packer.
// Shifts decoded bits in first-received-most-significant and ORs their
// error flags. On the last bit of a word it loads the output word, the
// violation flag (masked outside CMI) and a one-cycle strobe. The byte
// clock is the top half of the bit counter, so it falls exactly when a
// word is loaded. A restart discards the partial word.
// Assumes WORD_W is a power of two and at least 2.
module cmi_rx_packer #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmi_en,
    input  logic              restart,
    input  logic              bit_vld,
    input  logic              bit_val,
    input  logic              bit_err,
    output logic [WORD_W-1:0] word_q,
    output logic              lcv_q,
    output logic              word_vld_q,
    output logic              word_clk
);

    localparam int              CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(WORD_W / 2);

    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] shreg_q;
    logic              err_acc_q;
    logic [WORD_W-1:0] shreg_n;
    logic              err_n;

    // Next shift contents and accumulated error with the incoming bit.
    always_comb begin
        shreg_n = {shreg_q[WORD_W-2:0], bit_val};
        err_n   = err_acc_q | bit_err;
    end

    // Byte clock: high while the second half of a word is being gathered.
    always_comb begin
        word_clk = (cnt_q >= HALF);
    end

    // Count bits, gather the word and publish it on the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            shreg_q    <= '0;
            err_acc_q  <= 1'b0;
            word_q     <= '0;
            lcv_q      <= 1'b0;
            word_vld_q <= 1'b0;
        end else begin
            word_vld_q <= 1'b0;
            if (restart) begin
                cnt_q     <= bit_vld ? CNT_W'(1) : '0;
                err_acc_q <= bit_vld & bit_err;
                if (bit_vld) begin
                    shreg_q <= shreg_n;
                end
            end else if (bit_vld) begin
                shreg_q <= shreg_n;
                if (cnt_q == LAST) begin
                    cnt_q      <= '0;
                    err_acc_q  <= 1'b0;
                    word_q     <= shreg_n;
                    lcv_q      <= err_n & cmi_en;
                    word_vld_q <= 1'b1;
                end else begin
                    cnt_q     <= cnt_q + CNT_W'(1);
                    err_acc_q <= err_n;
                end
            end
        end
    end

    // R7: a word completed in an NRZ mode never carries the flag.
    assert_lcv_nrz_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld_q && !$past(cmi_en)) |-> !lcv_q);

    // R8: the outputs move only as the byte clock falls.
    assert_out_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(word_q) || !$stable(lcv_q)) |-> $fell(word_clk));

    // R8: word strobes are isolated single-cycle pulses.
    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld_q |=> !word_vld_q);

endmodule

// File: rtl/cmi_rx_deser.sv
// CMI receive deserializer top.
// Source select and retime -> symbol decode -> word packing.
// Assumes mode and lb_en are held steady except around a realign.
module cmi_rx_deser
    import cmi_rx_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode,
    input  logic              rx_in,
    input  logic              diag_in,
    input  logic              lb_en,
    input  logic              realign_en,
    output logic              lb_out,
    output logic [WORD_W-1:0] pout,
    output logic              lcv,
    output logic              byte_vld,
    output logic              byte_clk
);

    logic cmi_en;
    logic sym_q;
    logic realign_q;
    logic live_q;
    logic bit_vld;
    logic bit_val;
    logic bit_err;

    // Decode the mode code into the CMI/NRZ choice.
    always_comb begin
        cmi_en = mode_is_cmi(mode);
    end

    cmi_rx_src_sel u_src (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_in      (rx_in),
        .diag_in    (diag_in),
        .lb_en      (lb_en),
        .realign_in (realign_en),
        .sym_q      (sym_q),
        .realign_q  (realign_q),
        .live_q     (live_q)
    );

    cmi_rx_sym_dec u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmi_en  (cmi_en),
        .live    (live_q),
        .sym     (sym_q),
        .restart (realign_q),
        .bit_vld (bit_vld),
        .bit_val (bit_val),
        .bit_err (bit_err)
    );

    cmi_rx_packer #(.WORD_W(WORD_W)) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmi_en     (cmi_en),
        .restart    (realign_q),
        .bit_vld    (bit_vld),
        .bit_val    (bit_val),
        .bit_err    (bit_err),
        .word_q     (pout),
        .lcv_q      (lcv),
        .word_vld_q (byte_vld),
        .word_clk   (byte_clk)
    );

    // Loopback output is the retimed selected sample.
    always_comb begin
        lb_out = sym_q;
    end

    // R9: a reset cycle leaves every output cleared.
    assert_reset_clear_R9: assert property (@(posedge clk)
        !rst_n |=> (pout == '0 && !lcv && !byte_vld && !byte_clk && !lb_out));

endmodule

// File: tb/cmi_rx_deser_bench.sv
`timescale 1ns/1ps
module cmi_rx_deser_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode = 3'b000;
    logic       rx_in = 1'b0;
    logic       diag_in = 1'b0;
    logic       lb_en = 1'b0;
    logic       realign_en = 1'b0;
    logic       lb_out;
    logic [7:0] pout;
    logic       lcv;
    logic       byte_vld;
    logic       byte_clk;

    int  checks = 0;
    int  errors = 0;
    int  cyc = 0;
    bit  done = 1'b0;
    bit  bmark = 1'b0;
    bit  bknown = 1'b0;
    bit  bcmi = 1'b0;
    int  last_edge = 0;
    logic prev_bclk = 1'b0;

    typedef struct {
        logic [7:0] d;
        logic       l;
        int         c;
        logic       pb;
        logic       bc;
    } ev_t;
    ev_t evq[$];

    always #2.5 clk = ~clk;

    cmi_rx_deser u_cmi_rx_deser (
        .clk(clk), .rst_n(rst_n), .mode(mode), .rx_in(rx_in),
        .diag_in(diag_in), .lb_en(lb_en), .realign_en(realign_en),
        .lb_out(lb_out), .pout(pout), .lcv(lcv),
        .byte_vld(byte_vld), .byte_clk(byte_clk)
    );

    always @(posedge clk) cyc++;

    // Record every published word away from the active edge.
    always @(negedge clk) begin
        if (byte_vld) evq.push_back('{d: pout, l: lcv, c: cyc, pb: prev_bclk, bc: byte_clk});
        prev_bclk = byte_clk;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input bit s, input bit ra);
        @(negedge clk);
        if (lb_en) begin
            diag_in = s;
            rx_in = ~s;
        end else begin
            rx_in = s;
            diag_in = ~s;
        end
        realign_en = ra;
        last_edge = cyc + 1;
    endtask

    task automatic set_mode(input logic [2:0] m);
        @(negedge clk);
        mode = m;
        bcmi = (m == 3'b010) || (m == 3'b011);
        if (!bcmi) bknown = 1'b0;
    endtask

    // kind 0 clean, 1 injects a (1,0) pair on a zero, 2 repeats the mark level on a one.
    task automatic send_cmi_bit(input bit b, input bit ra, input int kind);
        bit lvl;
        if (!b) begin
            if (kind == 1) begin drive(1'b1, ra); drive(1'b0, 1'b0); end
            else begin drive(1'b0, ra); drive(1'b1, 1'b0); end
        end else begin
            lvl = bknown ? ((kind == 2) ? bmark : ~bmark) : 1'b1;
            drive(lvl, ra);
            drive(lvl, 1'b0);
            bmark = lvl;
            bknown = 1'b1;
        end
    endtask

    task automatic send_byte(input logic [7:0] v, input bit ra, input int pos,
                             input int kind, output int fe);
        fe = 0;
        for (int i = 0; i < 8; i++) begin
            if (bcmi) send_cmi_bit(v[7-i], ra && (i == 0), (i == pos) ? kind : 0);
            else drive(v[7-i], ra && (i == 0));
            if (i == 0) fe = bcmi ? last_edge - 1 : last_edge;
        end
    endtask

    task automatic expect_byte(input logic [7:0] d, input bit l, input int fe, input string tag);
        ev_t e;
        int  lat;
        lat = bcmi ? 16 : 8;
        for (int k = 0; k < 40 && evq.size() == 0; k++) begin
            if (bcmi) drive((k % 2) == 1, 1'b0);
            else drive(1'b0, 1'b0);
            #1;
        end
        if (evq.size() == 0) begin
            chk(1'b0, {tag, " word missing"}, 0, d);
            return;
        end
        e = evq.pop_front();
        chk(e.d == d, {tag, " R2 data"}, e.d, d);
        chk(e.l == l, {tag, " R6 lcv"}, e.l, l);
        chk(e.c - fe == lat, {tag, " R12 latency"}, e.c - fe, lat);
        chk(e.pb == 1'b1 && e.bc == 1'b0, {tag, " R8 byte_clk fall"}, {e.pb, e.bc}, 2'b10);
    endtask

    task automatic t_reset();
        int fe;
        repeat (3) @(negedge clk);
        chk(pout == 8'h00 && !lcv && !byte_vld && !byte_clk && !lb_out, "R9 reset outputs",
            {pout, lcv, byte_vld, byte_clk, lb_out}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        rx_in = 1'b1;
        fe = cyc + 1;
        for (int i = 1; i < 8; i++) drive(((8'h96 >> (7 - i)) & 1) != 0, 1'b0);
        bcmi = 1'b0;
        expect_byte(8'h96, 1'b0, fe, "R9 first sample");
    endtask

    task automatic t_nrz(input logic [2:0] m, input logic [7:0] a, input logic [7:0] b);
        int fa, fb;
        set_mode(m);
        evq.delete();
        send_byte(a, 1'b1, -1, 0, fa);
        send_byte(b, 1'b0, -1, 0, fb);
        expect_byte(a, 1'b0, fa, "R1 nrz first");
        expect_byte(b, 1'b0, fb, "R1 nrz second");
    endtask

    task automatic t_cmi_clean();
        int fa, fb;
        set_mode(3'b010);
        evq.delete();
        send_byte(8'h5A, 1'b1, -1, 0, fa);
        send_byte(8'hC3, 1'b0, -1, 0, fb);
        expect_byte(8'h5A, 1'b0, fa, "R3 cmi clean");
        expect_byte(8'hC3, 1'b0, fb, "R3 cmi clean b");
    endtask

    task automatic t_cmi_pair_err();
        int fa, fb;
        set_mode(3'b010);
        evq.delete();
        send_byte(8'hF0, 1'b1, 6, 1, fa);
        send_byte(8'hF0, 1'b0, -1, 0, fb);
        expect_byte(8'hF0, 1'b1, fa, "R4 pair 10");
        expect_byte(8'hF0, 1'b0, fb, "R6 clears next word");
    endtask

    task automatic t_cmi_alt_err();
        int fa, fb;
        set_mode(3'b011);
        evq.delete();
        send_byte(8'hFF, 1'b1, 5, 2, fa);
        send_byte(8'h00, 1'b0, -1, 0, fb);
        expect_byte(8'hFF, 1'b1, fa, "R5 repeated mark");
        expect_byte(8'h00, 1'b0, fb, "R6 clears after mark err");
    endtask

    task automatic t_nrz_lcv();
        int fa, fb;
        set_mode(3'b001);
        evq.delete();
        send_byte(8'hAA, 1'b1, -1, 0, fa);
        expect_byte(8'hAA, 1'b0, fa, "R7 nrz lcv low");
        set_mode(3'b110);
        evq.delete();
        send_byte(8'hE7, 1'b1, -1, 0, fb);
        expect_byte(8'hE7, 1'b0, fb, "R7 R1 reserved code nrz");
    endtask

    task automatic t_realign();
        int fa, fb;
        set_mode(3'b000);
        evq.delete();
        drive(1'b1, 1'b1); drive(1'b1, 1'b0); drive(1'b1, 1'b0);
        send_byte(8'h42, 1'b1, -1, 0, fa);
        expect_byte(8'h42, 1'b0, fa, "R10 nrz realign");
        set_mode(3'b010);
        evq.delete();
        drive(1'b1, 1'b1);
        send_byte(8'h24, 1'b1, -1, 0, fb);
        expect_byte(8'h24, 1'b0, fb, "R10 cmi realign");
    endtask

    task automatic t_loop();
        int fa;
        logic [7:0] v;
        v = 8'hD2;
        set_mode(3'b000);
        evq.delete();
        @(negedge clk);
        lb_en = 1'b1;
        for (int i = 0; i < 8; i++) begin
            drive(v[7-i], i == 0);
            if (i == 0) fa = last_edge;
            @(posedge clk);
            #0.5;
            chk(lb_out == v[7-i], "R11 lb_out diag", lb_out, v[7-i]);
        end
        expect_byte(v, 1'b0, fa, "R11 diag source");
        @(negedge clk);
        lb_en = 1'b0;
        drive(1'b1, 1'b0);
        @(posedge clk);
        #0.5;
        chk(lb_out == 1'b1, "R11 lb_out normal", lb_out, 1);
    endtask

    initial begin
        t_reset();
        t_nrz(3'b000, 8'hA5, 8'h3C);
        t_nrz(3'b001, 8'h81, 8'h7E);
        t_cmi_clean();
        t_cmi_pair_err();
        t_cmi_alt_err();
        t_nrz_lcv();
        t_realign();
        t_loop();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule